// File: doc/BRIEF.md
# Single PWM Channel with Selectable Counting Clock

This block produces one pulse-width-modulated waveform. The counting clock is one of two kinds. The first kind is a tap of a free-running power-of-two prescaler, which divides the input clock by 1, 2, 4 and so on up to 1024. The second kind is one of two independent linear dividers, each programmed with an 8-bit divide value. On every selected tick the channel counter steps. In edge mode it wraps at the period value. In symmetric mode it counts up to the period value and back down to zero.

The output is inactive while the counter is below the duty value and active otherwise. A polarity input inverts the output level. Period, duty and mode are copied into internal shadow registers only at the end of a period, so software can write them at any time without producing a runt pulse.

Top module: `pwm_chan`

## Requirements
- R1: Clock select codes 0 to 10 choose the prescaler tap that divides the input clock by 2^code. One counter step is taken every 2^code input cycles.
- R2: Clock select code 11 chooses linear divider A and code 12 chooses linear divider B. Each divider gives one counter step every N input cycles, where N is its 8-bit divide input and 1 ≤ N ≤ 255.
- R3: A divide value of 0 on the selected divider stops the channel counter. Clock select codes 13 to 15 also stop it. While the counter is stopped the output does not toggle.
- R4: In edge mode (`center_i`=0) the counter runs 0..P−1 and wraps. The output period is F·P input cycles, where F is the step interval. For 1 ≤ D < P the output is active for F·(P−D) cycles of each period.
- R5: In symmetric mode (`center_i`=1) the counter runs 0..P and then back down to 0. The output period is 2·F·P cycles. For 1 ≤ D < P the output is active for F·(2·(P−D)+1) cycles of each period.
- R6: A duty value of 0 makes the output active at all times. A duty value of P or more makes it inactive at all times. Both hold in either mode.
- R7: The active level is high when `invert_i`=0 and low when `invert_i`=1. During reset and before the first period, the output is at the inactive level.
- R8: Period, duty and mode inputs take effect only when a period ends. In edge mode this is at the wrap to 0. In symmetric mode it is when the down count reaches 0. A duty change made mid-period does not alter the current period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_sel_i | input | 4 | Counting clock select (0..10 prescaler tap, 11 divider A, 12 divider B) |
| div_a_i | input | 8 | Divide value of linear divider A (0 = off) |
| div_b_i | input | 8 | Divide value of linear divider B (0 = off) |
| center_i | input | 1 | 0 = edge mode, 1 = symmetric up/down mode |
| invert_i | input | 1 | Output polarity; 1 makes the active level low |
| period_i | input | CNT_W | Period value P |
| duty_i | input | CNT_W | Duty value D |
| pwm_o | output | 1 | Waveform output |

## Verification
Two functions can fall in the same cycle: the end-of-period reload of the shadow registers and a new duty value arriving on the inputs. The bench provokes this by changing the duty value at the very edge where the output turns active. It then follows the output through the remaining counts of the current period and into the next one. The old duty must govern until the wrap, and the new duty must set the edge in the following period. The sweeps also land reloads on every phase of the prescaler and the dividers, and the output is judged by active-cycle and transition counts over whole periods.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;
  localparam int unsigned N_TAPS = 11;
  localparam int unsigned SEL_W  = 4;
  localparam int unsigned DIV_W  = 8;
  localparam logic [SEL_W-1:0] SEL_DIV_A = 4'd11;
  localparam logic [SEL_W-1:0] SEL_DIV_B = 4'd12;
  typedef logic [SEL_W-1:0] clk_sel_t;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int unsigned N_TAPS = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [N_TAPS-1:0] tap_o
);
  localparam int unsigned CW = N_TAPS - 1;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;

  assign tap_o[0] = 1'b1;
  for (genvar k = 1; k < N_TAPS; k++) begin : g_tap
    assign tap_o[k] = &cnt_q[k-1:0];
  end

  // tap 1 pulses every other cycle
  assert_tap_alternates_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tap_o[1] |=> !tap_o[1]);
endmodule

// File: rtl/pwm_lin_div.sv
module pwm_lin_div #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] n_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] last;

  assign last   = n_i - 1'b1;
  assign tick_o = (n_i != '0) && (cnt_q == last);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                          cnt_q <= '0;
    else if (n_i == '0 || cnt_q >= last)  cnt_q <= '0;
    else                                  cnt_q <= cnt_q + 1'b1;

  assert_div_restart_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (cnt_q == '0));
  assert_div_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (n_i == '0) |-> !tick_o);
endmodule

// File: rtl/pwm_cnt_cmp.sv
module pwm_cnt_cmp #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             center_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] duty_i,
  output logic             active_o
);
  logic [CNT_W-1:0] cnt_q, cnt_n, prd_q, dty_q;
  logic             up_q, up_n, ctr_q, load;

  always_comb begin
    cnt_n = cnt_q;
    up_n  = up_q;
    load  = 1'b0;
    if (!ctr_q || prd_q == '0) begin
      up_n = 1'b1;
      if ({1'b0, cnt_q} + 1'b1 >= {1'b0, prd_q}) begin
        cnt_n = '0;
        load  = 1'b1;
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end else if (up_q && cnt_q < prd_q) begin
      cnt_n = cnt_q + 1'b1;
    end else begin
      // turnaround at the top, or down count
      cnt_n = cnt_q - 1'b1;
      up_n  = 1'b0;
      if (cnt_n == '0) begin
        load = 1'b1;
        up_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
      prd_q <= '0;
      dty_q <= '0;
      ctr_q <= 1'b0;
    end else if (tick_i) begin
      cnt_q <= cnt_n;
      up_q  <= up_n;
      if (load) begin
        prd_q <= period_i;
        dty_q <= duty_i;
        ctr_q <= center_i;
      end
    end

  assign active_o = (dty_q < prd_q) && (cnt_q >= dty_q);

  assert_hold_without_tick_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q));
  assert_edge_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctr_q && prd_q != '0) |-> cnt_q < prd_q);
  assert_sym_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctr_q |-> cnt_q <= prd_q);
  assert_reload_at_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(dty_q) || !$stable(prd_q)) |-> cnt_q == '0);
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_chan_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [3:0]       clk_sel_i,
  input  logic [7:0]       div_a_i,
  input  logic [7:0]       div_b_i,
  input  logic             center_i,
  input  logic             invert_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] duty_i,
  output logic             pwm_o
);
  logic [N_TAPS-1:0] taps;
  logic [1:0]        div_tick;
  logic [DIV_W-1:0]  div_n [2];
  logic              tick, active;

  assign div_n[0] = div_a_i;
  assign div_n[1] = div_b_i;

  pwm_prescaler #(.N_TAPS(N_TAPS)) u_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .tap_o(taps));

  for (genvar i = 0; i < 2; i++) begin : g_div
    pwm_lin_div #(.DIV_W(DIV_W)) u_div (
      .clk_i(clk_i), .rst_ni(rst_ni), .n_i(div_n[i]), .tick_o(div_tick[i]));
  end

  always_comb begin
    tick = 1'b0;
    if (clk_sel_i < clk_sel_t'(N_TAPS)) tick = taps[clk_sel_i];
    else if (clk_sel_i == SEL_DIV_A)    tick = div_tick[0];
    else if (clk_sel_i == SEL_DIV_B)    tick = div_tick[1];
  end

  pwm_cnt_cmp #(.CNT_W(CNT_W)) u_cc (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .center_i(center_i),
    .period_i(period_i), .duty_i(duty_i), .active_o(active));

  assign pwm_o = active ^ invert_i;

  assert_reset_inactive_R7: assert property (@(posedge clk_i)
    !rst_ni |-> (pwm_o == invert_i));
endmodule

// File: tb/pwm_chan_test.sv
module pwm_chan_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0]  sel = '0;
  logic [7:0]  div_a = 8'd1, div_b = 8'd1;
  logic        center = 1'b0, invert = 1'b0;
  logic [15:0] period = '0, duty = '0;
  logic        pwm;
  int checks = 0, fails = 0, cyc = 0;

  always #2.5 clk = ~clk;

  pwm_chan uut (
    .clk_i(clk), .rst_ni(rst_n), .clk_sel_i(sel), .div_a_i(div_a), .div_b_i(div_b),
    .center_i(center), .invert_i(invert), .period_i(period), .duty_i(duty), .pwm_o(pwm));

  always @(posedge clk) begin
    cyc++;
    if (cyc == 195000) begin
      checks++; fails++;
      $display("FAIL watchdog expired: actual %0d cycles expected < 195000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R7 reset level", int'(pwm), int'(invert));
    rst_n = 1'b1;
  endtask

  // f: step interval in input cycles; halted: counter expected stopped
  task automatic run_cfg(input logic [3:0] s, input bit ctr, input bit inv,
                         input int p, input int d, input int f, input bit halted,
                         input string rate_tag);
    int t, act, act_cnt, trans;
    logic prev;
    sel = s; center = ctr; invert = inv; period = 16'(p); duty = 16'(d);
    do_reset();
    t = halted ? 16 : (ctr ? 2*f*p : f*p);
    if (halted || d >= p)  act = 0;
    else if (d == 0)       act = t;
    else if (ctr)          act = f*(2*(p-d)+1);
    else                   act = f*(p-d);
    repeat (2*t + 8) @(negedge clk);
    prev = pwm; act_cnt = 0; trans = 0;
    for (int i = 0; i < 2*t; i++) begin
      @(negedge clk);
      if (pwm != inv) act_cnt++;
      if (pwm != prev) trans++;
      prev = pwm;
    end
    if (halted) begin
      check("R3 stopped active count", act_cnt, 0);
      check("R3 stopped transitions", trans, 0);
    end else begin
      check((d == 0 || d >= p) ? "R6 active count" : (ctr ? "R5 active count" : "R4 active count"),
            act_cnt, 2*act);
      check(rate_tag, trans, (act == 0 || act == t) ? 0 : 4);
    end
  endtask

  initial begin
    // edge mode, prescaler taps 1,2,4,8
    for (int k = 0; k < 4; k++)
      for (int p = 1; p <= 6; p++)
        for (int d = 0; d <= 7; d++)
          run_cfg(4'(k), 1'b0, p[0], p, d, 1 << k, 1'b0, "R1 period via transitions");
    // symmetric mode, tap 1 and divider A = 2
    for (int p = 1; p <= 5; p++)
      for (int d = 0; d <= 6; d++) begin
        run_cfg(4'd0, 1'b1, d[0], p, d, 1, 1'b0, "R5 period via transitions");
        div_a = 8'd2;
        run_cfg(4'd11, 1'b1, p[0], p, d, 2, 1'b0, "R2 divider A symmetric");
      end
    // largest tap
    run_cfg(4'd10, 1'b0, 1'b0, 2, 1, 1024, 1'b0, "R1 tap 1024");
    // divider A and B in edge mode
    div_a = 8'd3; div_b = 8'd5;
    for (int d = 1; d <= 3; d++) begin
      run_cfg(4'd11, 1'b0, 1'b0, 4, d, 3, 1'b0, "R2 divider A=3");
      run_cfg(4'd12, 1'b0, 1'b1, 4, d, 5, 1'b0, "R2 divider B=5");
    end
    div_b = 8'd255;
    run_cfg(4'd12, 1'b0, 1'b0, 2, 1, 255, 1'b0, "R2 divider B=255");
    // stopped counter
    div_a = 8'd0;
    run_cfg(4'd11, 1'b0, 1'b0, 4, 2, 1, 1'b1, "R3");
    run_cfg(4'd13, 1'b0, 1'b1, 4, 2, 1, 1'b1, "R3");
    run_cfg(4'd15, 1'b1, 1'b0, 4, 2, 1, 1'b1, "R3");

    // R8: duty change mid-period does not affect the current period
    sel = 4'd0; center = 1'b0; invert = 1'b0; period = 16'd8; duty = 16'd2;
    do_reset();
    repeat (20) @(negedge clk);
    begin
      logic prev;
      prev = pwm;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        if (!prev && pwm) break;
        prev = pwm;
      end
    end
    duty = 16'd6;  // counter is at 2 here
    for (int i = 1; i <= 5; i++) begin
      @(negedge clk);
      check("R8 old duty holds to wrap", int'(pwm), 1);
    end
    @(negedge clk);
    check("R8 low after wrap", int'(pwm), 0);
    repeat (5) @(negedge clk);
    check("R8 new duty still low at count 5", int'(pwm), 0);
    @(negedge clk);
    check("R8 new duty active at count 6", int'(pwm), 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule